// File: doc/BRIEF.md
# External Bus Cycle Timing Generator

This block shapes the read and write strobes for every access that a processor-side requester launches. A requester raises a one-cycle start together with a region number and a direction flag. Regions 0 to 3 are external chip-select spaces. Region 4 is on-chip memory and region 5 is the special-function register area. For an external space the block drives that space's active-low chip select, then the active-low read or write strobe, and then an optional quiet recovery cycle. It ends with a one-cycle done pulse. On-chip regions drive no pins. They only keep the block busy for a fixed short time before the done pulse.

Each external space owns a six-bit timing byte. The lower five bits hold a sparse code that gives two counts: the cycles from the start of the access to the falling strobe, and the cycles the strobe stays low. Bit 5 requests the trailing recovery cycle. An unsupported code falls back to the power-up timing and sets a sticky error flag. Two global inputs each add one wait cycle: one to on-chip memory accesses and one to register-area accesses. A timing byte that changes while an access runs affects only the accesses that start later.

Top module: `ext_bus_timer`

## Requirements
- R1: While reset is held and after it is released, rd_n, wr_n and all cs_n bits are 1, busy, done and cfg_err are 0, and every timing byte reads back as 8'h03.
- R2: A write with cfg_we high stores cfg_wdata[5:0] into the timing byte picked by cfg_sel. cfg_rdata always shows the byte picked by cfg_sel, with bits 7:6 reading 0.
- R3: Byte bits 4:0 select a setup count S and a strobe count L: 00001..00110 give S=1 with L=1..6, 01010..01101 give S=2 with L=2..5, and 10011..10110 give S=3 with L=3..6. An access is accepted at a clock edge. For the next S cycles cs_n[region] is low and both strobes are high. For the L cycles after that, cs_n[region] stays low and rd_n (req_write=0) or wr_n (req_write=1) is low.
- R4: When byte bit 5 is 1, one extra cycle follows the strobe-low cycles, with all cs_n bits and both strobes high. When bit 5 is 0, no cycle is added.
- R5: busy is 1 from the cycle after acceptance through the done cycle. done is high for exactly one cycle, which is the cycle right after the last strobe-low or recovery cycle, and busy is 0 in the following cycle.
- R6: Any other 5-bit code times the access as S=1, L=3. Writing such a code sets cfg_err, and only reset clears it.
- R7: A start for region 4 drives no strobe or chip select. It keeps busy high for 1 cycle before done, or 2 cycles when int_wait is 1 at acceptance.
- R8: A start for region 5 drives no strobe or chip select. It keeps busy high for 2 cycles before done, or 3 cycles when sfr_wait is 1 at acceptance.
- R9: A start is ignored while busy is 1, including in the done cycle. A start with region 6 or 7 is ignored. While busy is 0, no strobe or chip select is active.
- R10: The timing byte, int_wait and sfr_wait are sampled at acceptance. A change during an access does not alter that access.
- R11: At most one cs_n bit is low at a time, and rd_n and wr_n are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Timing byte write enable |
| cfg_sel | input | 2 | Timing byte select (space number) |
| cfg_wdata | input | 8 | Timing byte write data |
| cfg_rdata | output | 8 | Selected timing byte, bits 7:6 zero |
| cfg_err | output | 1 | Sticky flag: an unsupported code was written |
| int_wait | input | 1 | Adds one cycle to on-chip memory accesses |
| sfr_wait | input | 1 | Adds one cycle to register-area accesses |
| req_start | input | 1 | Access start request |
| req_region | input | 3 | 0-3 external space, 4 on-chip memory, 5 register area |
| req_write | input | 1 | 1 = write, 0 = read |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| cs_n | output | 4 | Active-low chip selects, one per external space |

## Verification
The assertions assume that reset is applied at the start and that region numbers above 5 are only ever ignored. They also assume the requester may hold req_start high for any length of time, so acceptance depends only on busy. The stimulus pulses req_start for one cycle in most accesses. It holds req_start high across a whole access and into the done cycle to test the ignored start. It sends regions 6 and 7 on purpose, and it changes a timing byte while its own space's access is running.

// File: rtl/ebt_pkg.sv
// Package: shared widths, reset value and sequencer state for the
// external bus cycle timing generator.
package ebt_pkg;
    localparam int CNT_W    = 3;      // holds counts up to 6 minus one
    localparam int CODE_W   = 5;      // timing code field width
    localparam int CFG_W    = 6;      // implemented bits of a timing byte
    localparam int REC_BIT  = 5;      // recovery request bit position
    localparam logic [CFG_W-1:0] CFG_RESET = 6'b000011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_RECOV,
        ST_INNER,
        ST_DONE
    } ebt_state_e;
endpackage

// File: rtl/ebt_code_decode.sv
// Timing code decoder: turns a sparse 5-bit code into a setup count and a
// strobe-low count. Unsupported codes fall back to 1+3 and report illegal.
// Assumes: purely combinational, no state.
module ebt_code_decode
    import ebt_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  setup,
    output logic [CNT_W-1:0]  low,
    output logic              legal
);
    logic [1:0] grp;
    logic [2:0] len;

    // Split the code: upper bits pick the setup group, lower bits the width.
    always_comb begin
        grp = code[4:3];
        len = code[2:0];
        unique case (grp)
            2'd0:    legal = (len >= 3'd1) && (len <= 3'd6);
            2'd1:    legal = (len >= 3'd2) && (len <= 3'd5);
            2'd2:    legal = (len >= 3'd3) && (len <= 3'd6);
            default: legal = 1'b0;
        endcase
        if (legal) begin
            setup = CNT_W'(grp) + CNT_W'(1);
            low   = CNT_W'(len);
        end else begin
            setup = CNT_W'(1);
            low   = CNT_W'(3);
        end
    end
endmodule

// File: rtl/ebt_cfg_bank.sv
// Timing byte bank: one six-bit register per external space, a read mux and
// the sticky unsupported-code flag.
// Assumes: N_SPACE is a power of two so cfg_sel covers exactly the spaces.
module ebt_cfg_bank
    import ebt_pkg::*;
#(
    parameter int N_SPACE = 4,
    localparam int SEL_W  = $clog2(N_SPACE)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [SEL_W-1:0]              cfg_sel,
    input  logic [CFG_W-1:0]              cfg_wdata,
    output logic [N_SPACE-1:0][CFG_W-1:0] cfg_q,
    output logic [7:0]                    cfg_rdata,
    output logic                          cfg_err
);
    logic [CNT_W-1:0] wr_setup;
    logic [CNT_W-1:0] wr_low;
    logic             wr_legal;
    logic             unused_wr_counts;

    ebt_code_decode u_wr_check (
        .code  (cfg_wdata[CODE_W-1:0]),
        .setup (wr_setup),
        .low   (wr_low),
        .legal (wr_legal)
    );
    assign unused_wr_counts = ^{wr_setup, wr_low};

    for (genvar gi = 0; gi < N_SPACE; gi++) begin : g_byte
        // Hold one space's timing byte; load it when that space is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[gi] <= CFG_RESET;
            end else if (cfg_we && (cfg_sel == SEL_W'(gi))) begin
                cfg_q[gi] <= cfg_wdata;
            end
        end
    end

    // Sticky flag: set by a write of an unsupported code, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else if (cfg_we && !wr_legal) begin
            cfg_err <= 1'b1;
        end
    end

    // Read mux: unimplemented top bits read as zero.
    always_comb begin
        cfg_rdata = {2'b00, cfg_q[cfg_sel]};
    end
endmodule

// File: rtl/ebt_seq.sv
// Access sequencer: accepts a start while idle, latches the timing, then
// steps through setup, strobe-low, optional recovery (or an internal wait)
// and a one-cycle done state.
// Assumes: start_ok is already qualified by a legal region; setup_in,
// low_in and inner_in are at least 1.
module ebt_seq
    import ebt_pkg::*;
#(
    parameter int N_SPACE = 4,
    localparam int SEL_W  = $clog2(N_SPACE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_ok,
    input  logic               go_ext,
    input  logic [SEL_W-1:0]   space_idx,
    input  logic               write_in,
    input  logic [CNT_W-1:0]   setup_in,
    input  logic [CNT_W-1:0]   low_in,
    input  logic               rec_in,
    input  logic [CNT_W-1:0]   inner_in,
    output logic               busy,
    output logic               done,
    output logic               rd_n,
    output logic               wr_n,
    output logic [N_SPACE-1:0] cs_n
);
    ebt_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] low_q;
    logic             rec_q;
    logic             wr_q;
    logic [SEL_W-1:0] idx_q;

    // Main state machine with a shared down-counter for every phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            low_q <= '0;
            rec_q <= 1'b0;
            wr_q  <= 1'b0;
            idx_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        low_q <= low_in;
                        rec_q <= rec_in;
                        wr_q  <= write_in;
                        idx_q <= space_idx;
                        if (go_ext) begin
                            state <= ST_SETUP;
                            cnt   <= setup_in - CNT_W'(1);
                        end else begin
                            state <= ST_INNER;
                            cnt   <= inner_in - CNT_W'(1);
                        end
                    end
                end
                ST_SETUP: begin
                    if (cnt == '0) begin
                        state <= ST_STROBE;
                        cnt   <= low_q - CNT_W'(1);
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_STROBE: begin
                    if (cnt == '0) begin
                        state <= rec_q ? ST_RECOV : ST_DONE;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_RECOV: state <= ST_DONE;
                ST_INNER: begin
                    if (cnt == '0) begin
                        state <= ST_DONE;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Pin decode from the current phase.
    always_comb begin
        busy = (state != ST_IDLE);
        done = (state == ST_DONE);
        rd_n = !((state == ST_STROBE) && !wr_q);
        wr_n = !((state == ST_STROBE) && wr_q);
        cs_n = '1;
        if ((state == ST_SETUP) || (state == ST_STROBE)) begin
            cs_n[idx_q] = 1'b0;
        end
    end
endmodule

// File: rtl/ext_bus_timer.sv
// External bus cycle timing generator top: timing byte bank, one decoder
// per space, region classification and the access sequencer.
// Assumes: region N_SPACE is on-chip memory, N_SPACE+1 the register area,
// and anything above is not a region.
module ext_bus_timer
    import ebt_pkg::*;
#(
    parameter int N_SPACE  = 4,
    localparam int SEL_W   = $clog2(N_SPACE),
    localparam int RGN_W   = $clog2(N_SPACE + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [7:0]         cfg_wdata,
    output logic [7:0]         cfg_rdata,
    output logic               cfg_err,
    input  logic               int_wait,
    input  logic               sfr_wait,
    input  logic               req_start,
    input  logic [RGN_W-1:0]   req_region,
    input  logic               req_write,
    output logic               busy,
    output logic               done,
    output logic               rd_n,
    output logic               wr_n,
    output logic [N_SPACE-1:0] cs_n
);
    logic [N_SPACE-1:0][CFG_W-1:0] cfg_q;
    logic [N_SPACE-1:0][CNT_W-1:0] dec_setup;
    logic [N_SPACE-1:0][CNT_W-1:0] dec_low;
    logic [N_SPACE-1:0]            dec_legal;
    logic                          unused_cfg_bits;
    logic                          is_ext;
    logic                          is_int;
    logic                          is_sfr;
    logic                          start_ok;
    logic [SEL_W-1:0]              space_idx;
    logic [CNT_W-1:0]              inner_len;

    assign unused_cfg_bits = ^{cfg_wdata[7:CFG_W], dec_legal};

    ebt_cfg_bank #(.N_SPACE(N_SPACE)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata[CFG_W-1:0]),
        .cfg_q     (cfg_q),
        .cfg_rdata (cfg_rdata),
        .cfg_err   (cfg_err)
    );

    for (genvar gi = 0; gi < N_SPACE; gi++) begin : g_dec
        ebt_code_decode u_dec (
            .code  (cfg_q[gi][CODE_W-1:0]),
            .setup (dec_setup[gi]),
            .low   (dec_low[gi]),
            .legal (dec_legal[gi])
        );
    end

    // Classify the requested region and pick the on-chip wait length.
    always_comb begin
        is_ext    = (req_region < RGN_W'(N_SPACE));
        is_int    = (req_region == RGN_W'(N_SPACE));
        is_sfr    = (req_region == RGN_W'(N_SPACE + 1));
        start_ok  = req_start && (is_ext || is_int || is_sfr);
        space_idx = req_region[SEL_W-1:0];
        if (is_int) begin
            inner_len = int_wait ? CNT_W'(2) : CNT_W'(1);
        end else begin
            inner_len = sfr_wait ? CNT_W'(3) : CNT_W'(2);
        end
    end

    ebt_seq #(.N_SPACE(N_SPACE)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_ok  (start_ok),
        .go_ext    (is_ext),
        .space_idx (space_idx),
        .write_in  (req_write),
        .setup_in  (dec_setup[space_idx]),
        .low_in    (dec_low[space_idx]),
        .rec_in    (cfg_q[space_idx][REC_BIT]),
        .inner_in  (inner_len),
        .busy      (busy),
        .done      (done),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .cs_n      (cs_n)
    );
endmodule

// File: rtl/ebt_checks.sv
// Protocol checker for the external bus cycle timing generator, bound to
// every instance of the top module.
module ebt_checks #(
    parameter int N_SPACE = 4,
    localparam int RGN_W  = $clog2(N_SPACE + 2)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_start,
    input logic [RGN_W-1:0]   req_region,
    input logic               cfg_err,
    input logic               busy,
    input logic               done,
    input logic               rd_n,
    input logic               wr_n,
    input logic [N_SPACE-1:0] cs_n
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rd_n && wr_n && (&cs_n))); // R9
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~rd_n, ~wr_n})); // R11
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)); // R11
    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> !(&cs_n)); // R3
    AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && $past(!rd_n)) |-> $stable(cs_n)); // R3
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rd_n && wr_n && (&cs_n))); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R5
    AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_start && (req_region < RGN_W'(N_SPACE + 2))) |=> busy); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err); // R6
endmodule

bind ext_bus_timer ebt_checks #(.N_SPACE(N_SPACE)) u_ebt_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_start  (req_start),
    .req_region (req_region),
    .cfg_err    (cfg_err),
    .busy       (busy),
    .done       (done),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .cs_n       (cs_n)
);

// File: tb/test_ext_bus_timer.sv
`timescale 1ns/1ps
module test_ext_bus_timer;
    localparam int CLK_PERIOD = 10;
    localparam int N_SPACE    = 4;
    localparam int WATCHDOG   = 20000;

    logic       clk, rst_n, cfg_we, cfg_err, int_wait, sfr_wait;
    logic [1:0] cfg_sel;
    logic [7:0] cfg_wdata, cfg_rdata;
    logic       req_start, req_write, busy, done, rd_n, wr_n;
    logic [2:0] req_region;
    logic [3:0] cs_n;

    ext_bus_timer #(.N_SPACE(N_SPACE)) i_ext_bus_timer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
        .int_wait(int_wait), .sfr_wait(sfr_wait), .req_start(req_start),
        .req_region(req_region), .req_write(req_write), .busy(busy),
        .done(done), .rd_n(rd_n), .wr_n(wr_n), .cs_n(cs_n)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;
    bit model_on = 0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference timing table taken from the requirements.
    function automatic void ref_timing(input logic [4:0] c, output int s,
                                       output int l, output bit ok);
        ok = 1;
        case (c)
            5'b00001: begin s = 1; l = 1; end
            5'b00010: begin s = 1; l = 2; end
            5'b00011: begin s = 1; l = 3; end
            5'b00100: begin s = 1; l = 4; end
            5'b00101: begin s = 1; l = 5; end
            5'b00110: begin s = 1; l = 6; end
            5'b01010: begin s = 2; l = 2; end
            5'b01011: begin s = 2; l = 3; end
            5'b01100: begin s = 2; l = 4; end
            5'b01101: begin s = 2; l = 5; end
            5'b10011: begin s = 3; l = 3; end
            5'b10100: begin s = 3; l = 4; end
            5'b10101: begin s = 3; l = 5; end
            5'b10110: begin s = 3; l = 6; end
            default:  begin s = 1; l = 3; ok = 0; end
        endcase
    endfunction

    function automatic string tag_name(input int t);
        case (t)
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    typedef struct {
        logic       rd_n;
        logic       wr_n;
        logic [3:0] cs_n;
        logic       done;
        logic       busy;
        int         tag;
    } exp_t;

    exp_t       q[$];
    exp_t       cur;
    exp_t       e;
    logic [5:0] mcfg [N_SPACE];
    logic       merr;
    int         ms, ml, mn;
    bit         mok;
    logic [5:0] mc;

    function automatic exp_t mk(input logic r, input logic w, input logic [3:0] c,
                                input logic d, input logic b, input int t);
        exp_t x;
        x.rd_n = r; x.wr_n = w; x.cs_n = c; x.done = d; x.busy = b; x.tag = t;
        return x;
    endfunction

    // Behavioural reference: per-cycle expected pins kept in a queue.
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            cur = mk(1, 1, 4'hF, 0, 0, 9);
            for (int i = 0; i < N_SPACE; i++) mcfg[i] = 6'h03;
            merr = 0;
        end else begin
            if (!cur.busy && req_start && req_region <= 3'd5) begin
                if (req_region < 3'd4) begin
                    mc = mcfg[req_region[1:0]];
                    ref_timing(mc[4:0], ms, ml, mok);
                    for (int k = 0; k < ms; k++)
                        q.push_back(mk(1, 1, ~(4'b1 << req_region[1:0]), 0, 1, mok ? 3 : 6));
                    for (int k = 0; k < ml; k++)
                        q.push_back(mk(req_write, !req_write, ~(4'b1 << req_region[1:0]),
                                       0, 1, mok ? 3 : 6));
                    if (mc[5]) q.push_back(mk(1, 1, 4'hF, 0, 1, 4));
                end else begin
                    if (req_region == 3'd4) mn = int_wait ? 2 : 1;
                    else                    mn = sfr_wait ? 3 : 2;
                    for (int k = 0; k < mn; k++)
                        q.push_back(mk(1, 1, 4'hF, 0, 1, req_region == 3'd4 ? 7 : 8));
                end
                q.push_back(mk(1, 1, 4'hF, 1, 1, 5));
            end
            if (cfg_we) begin
                ref_timing(cfg_wdata[4:0], ms, ml, mok);
                mcfg[cfg_sel] = cfg_wdata[5:0];
                if (!mok) merr = 1;
            end
            if (q.size() > 0) cur = q.pop_front();
            else              cur = mk(1, 1, 4'hF, 0, 0, 9);
        end
    end

    // Compare the design against the reference on every clock.
    always @(negedge clk) begin
        if (rst_n && model_on && !finished) begin
            check(tag_name(cur.tag), "pins {rd,wr,cs,done,busy}",
                  {rd_n, wr_n, cs_n, done, busy},
                  {cur.rd_n, cur.wr_n, cur.cs_n, cur.done, cur.busy});
            check("R2/R6", "{err,rdata}", {cfg_err, cfg_rdata},
                  {merr, 2'b00, mcfg[cfg_sel]});
            check("R11", "strobe and select exclusivity",
                  ($countones(~cs_n) <= 1) && !(!rd_n && !wr_n), 1);
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wr_cfg(input logic [1:0] sel, input logic [7:0] data);
        step();
        cfg_we = 1; cfg_sel = sel; cfg_wdata = data;
        step();
        cfg_we = 0;
    endtask

    task automatic access(input logic [2:0] rgn, input logic w, output int len);
        step();
        req_start = 1; req_region = rgn; req_write = w;
        step();
        req_start = 0;
        len = 0;
        while (busy) begin
            len++;
            step();
        end
    endtask

    function automatic int exp_len(input logic [5:0] c);
        int s, l;
        bit ok;
        ref_timing(c[4:0], s, l, ok);
        return s + l + int'(c[5]) + 1;
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    logic [4:0] codes [14];
    int         len;

    initial begin
        codes = '{5'h01, 5'h02, 5'h03, 5'h04, 5'h05, 5'h06, 5'h0A,
                  5'h0B, 5'h0C, 5'h0D, 5'h13, 5'h14, 5'h15, 5'h16};
        rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; int_wait = 0;
        sfr_wait = 0; req_start = 0; req_region = 0; req_write = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "pins in reset", {rd_n, wr_n, cs_n, done, busy, cfg_err},
              {1'b1, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0});
        for (int i = 0; i < N_SPACE; i++) begin
            cfg_sel = 2'(i);
            #1;
            check("R1", "reset timing byte", cfg_rdata, 8'h03);
        end
        cfg_sel = 0;
        #1;
        rst_n = 1;
        model_on = 1;

        // R1 and R3: power-up timing, 1+3, read
        access(3'd0, 1'b0, len);
        check("R3", "default access length", len, 5);

        // R3 and R4: every supported code, alternating recovery and direction
        for (int i = 0; i < 14; i++) begin
            logic [7:0] b;
            b = {2'(i), 1'(i % 2), codes[i]};
            wr_cfg(2'(i % 4), b);
            access(3'(i % 4), 1'(i % 3 == 0), len);
            check(i % 2 ? "R4" : "R3", "access length", len, exp_len(b[5:0]));
        end

        // R2: upper bits are discarded on write
        wr_cfg(2'd0, 8'hC5);
        cfg_sel = 2'd0;
        #1;
        check("R2", "readback hides bits 7:6", cfg_rdata, 8'h05);

        // R6: unsupported code falls back and sets the sticky flag
        wr_cfg(2'd2, 8'h07);
        check("R6", "error flag after bad code", cfg_err, 1);
        access(3'd2, 1'b1, len);
        check("R6", "fallback length", len, 5);
        wr_cfg(2'd2, 8'h02);
        check("R6", "error flag stays set", cfg_err, 1);

        // R7 and R8: on-chip regions with and without the wait inputs
        access(3'd4, 1'b0, len);
        check("R7", "on-chip length", len, 2);
        int_wait = 1;
        access(3'd4, 1'b1, len);
        check("R7", "on-chip length with wait", len, 3);
        access(3'd5, 1'b0, len);
        check("R8", "register area length", len, 3);
        sfr_wait = 1;
        access(3'd5, 1'b1, len);
        check("R8", "register area length with wait", len, 4);

        // R9: regions 6 and 7 are ignored
        access(3'd6, 1'b0, len);
        check("R9", "region 6 ignored", len, 0);
        access(3'd7, 1'b1, len);
        check("R9", "region 7 ignored", len, 0);

        // R9: a start held through an access and its done cycle is ignored
        wr_cfg(2'd1, 8'h03);
        step();
        req_start = 1; req_region = 3'd1; req_write = 0;
        step();
        len = 0;
        while (busy) begin
            len++;
            step();
        end
        req_start = 0;
        check("R9", "held start makes one access", len, 5);
        step();
        check("R9", "no second access after held start", busy, 0);

        // R10: a timing byte changed mid-access applies only to the next one
        wr_cfg(2'd3, 8'h06);
        int_wait = 0;
        step();
        req_start = 1; req_region = 3'd3; req_write = 1;
        step();
        req_start = 0;
        cfg_we = 1; cfg_sel = 2'd3; cfg_wdata = 8'h21;
        int_wait = 1;
        len = 1;
        step();
        cfg_we = 0;
        while (busy) begin
            len++;
            step();
        end
        check("R10", "running access keeps old timing", len, 8);
        access(3'd3, 1'b0, len);
        check("R10", "next access uses new timing", len, 4);

        step();
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL R5 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule